// File: doc/BRIEF.md
# Transducer Request Dispatcher

This block terminates the byte link from a network processor to a board of local transducer resources. Every request opens with a one-byte address word that holds a direction flag, a function code and a channel code. The block decodes that word and then runs the request against one of four targets: a 12-bit sampled analog input, a set of read-only data sheets, a bank of actuator output registers, or a self-test fault mask. It returns the reply bytes on the transmit side and then waits for the next request.

The serializer on each side of the link is modelled as a valid/ready byte port. The converter is a request/valid pair that returns one sample for the channel the block presents. The block handles exactly one request at a time. While it waits for a sample or sends a reply, it accepts no new byte.

Top module: `xdcr_dispatch`

## Requirements
- R1: After reset, rxReady is 1, txValid is 0, adcReq is 0 and every actuator output byte is 0.
- R2: The address byte is decoded as follows. Bit 7 is the direction (1 = read). Bits 6:5 are the function (00 sensor, 01 data sheet, 10 actuator, 11 self-test). Bits 4:0 are the channel. Once the last reply byte is taken, the block shows txValid 0 and rxReady 1 again.
- R3: A sensor read (bit 7 = 1, function 00, channel below 17) holds adcReq with adcChan equal to the channel until adcValid. It then replies with two bytes: {4'b0, sample[11:8]} first, then sample[7:0].
- R4: A sensor read on channel 17 or above replies with the single byte 0xEE and raises no adcReq.
- R5: A data-sheet read on channel 0 replies with 100 bytes. The first four are 0x60, 0x00, 0x00, 0x00 (the body length 96, least significant byte first). Body byte k is 17 for k = 0, 4 for k = 1, and otherwise k XOR 0xA5.
- R6: A data-sheet read on channel c with 1 <= c <= 17 replies with 8 bytes: 0x01 (calibration key), 0x00 (sensor type), c-1, 12 (sample bits), then 0x11, 0x01, 0x43, 0x01 (range 273 to 323 as little-endian 16-bit values). A channel above 17 replies 0xEE.
- R7: An actuator write (bit 7 = 0, function 10) consumes one further byte. On channel c < 4 that byte is stored into actOut[8c+7:8c] and the reply is 0xAC. On channel 4 or above the reply is 0xEE and no output changes. Outputs change only when the data byte is accepted.
- R8: A self-test (bit 7 = 1, function 11) replies with one byte equal to faultIn as sampled when the address byte is accepted. 0x00 means pass.
- R9: When the direction conflicts with the function (a write to a sensor, data sheet or self-test, or a read of an actuator), the block replies 0xEE only. It raises no adcReq, and the next received byte is decoded as a new address.
- R10: Once txValid is asserted, it stays asserted with txData unchanged until txReady. rxReady is 0 while a reply is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received byte valid |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Block accepts a received byte |
| txValid | output | 1 | Reply byte valid |
| txData | output | 8 | Reply byte |
| txReady | input | 1 | Link accepts the reply byte |
| adcReq | output | 1 | Sample request to the converter |
| adcChan | output | 5 | Channel to sample |
| adcValid | input | 1 | Sample available |
| adcData | input | 12 | Converter sample |
| faultIn | input | 8 | Module fault mask for self-test |
| actOut | output | 32 | Four actuator output bytes, actuator 0 in the low byte |

## Verification
Directed requests cover each function at its channel edges: channel 0, 16 and 17 for sensors, channel 0, 1, 17 and 18 for data sheets, and channel 3 and 4 for actuators. Samples of all ones and all zeros check that the nibbles land in the right bytes. Each direction-conflict case is followed at once by a real request, which shows whether a stray byte was swallowed. After that, several hundred random address bytes, with random data, samples, fault masks, converter latency and transmit stalls, exercise every combination of direction, function and channel. These runs separate decode mistakes, off-by-one channel limits, wrong reply lengths and loss of held reply data.

// File: rtl/xdcr_pkg.sv
package xdcr_pkg;
  typedef enum logic [2:0] {
    RK_ERR, RK_SAMPLE, RK_META, RK_CHAN, RK_ACK, RK_TEST
  } replyKind_t;

  typedef struct packed {
    logic       latchAddr;
    logic       latchSample;
    logic       writeAct;
    logic       setKind;
    replyKind_t kind;
    logic       advance;
  } dpCmd_t;

  localparam logic [1:0] FN_SENSOR = 2'b00;
  localparam logic [1:0] FN_SHEET  = 2'b01;
  localparam logic [1:0] FN_ACT    = 2'b10;
  localparam logic [1:0] FN_TEST   = 2'b11;

  localparam logic [7:0] ERR_BYTE = 8'hEE;
  localparam logic [7:0] ACK_BYTE = 8'hAC;
endpackage

// File: rtl/xdcr_datapath.sv
module xdcr_datapath
  import xdcr_pkg::*;
#(
  parameter int NUM_CH    = 17,
  parameter int NUM_ACT   = 4,
  parameter int SAMPLE_W  = 12,
  parameter int META_BODY = 96
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCmd_t               cmd,
  input  logic [7:0]           rxData,
  input  logic [SAMPLE_W-1:0]  adcData,
  input  logic [7:0]           faultIn,
  output logic [4:0]           chanQ,
  output logic [7:0]           curByte,
  output logic                 lastByte,
  output logic [8*NUM_ACT-1:0] actOut
);
  localparam int META_LEN = 4 + META_BODY;
  localparam int CH_LEN   = 8;
  localparam int IDX_W    = $clog2(META_LEN + 1);

  logic [SAMPLE_W-1:0] sampleQ;
  logic [7:0]          faultQ;
  replyKind_t          kindQ;
  logic [IDX_W-1:0]    idxQ;
  logic [IDX_W-1:0]    replyLen;
  logic [IDX_W-1:0]    metaK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ   <= '0;
      sampleQ <= '0;
      faultQ  <= '0;
      kindQ   <= RK_ERR;
      idxQ    <= '0;
    end else begin
      if (cmd.latchAddr)   chanQ   <= rxData[4:0];
      if (cmd.latchSample) sampleQ <= adcData;
      if (cmd.setKind) begin
        kindQ  <= cmd.kind;
        idxQ   <= '0;
        faultQ <= faultIn;
      end else if (cmd.advance) begin
        idxQ <= idxQ + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_ACT; i++) begin : g_act
    always_ff @(posedge clk) begin
      if (!rstN) actOut[8*i +: 8] <= '0;
      else if (cmd.writeAct && chanQ == 5'(i)) actOut[8*i +: 8] <= rxData;
    end
  end

  always_comb begin
    unique case (kindQ)
      RK_SAMPLE: replyLen = IDX_W'(2);
      RK_META:   replyLen = IDX_W'(META_LEN);
      RK_CHAN:   replyLen = IDX_W'(CH_LEN);
      default:   replyLen = IDX_W'(1);
    endcase
  end

  assign lastByte = (idxQ == replyLen - 1'b1);
  assign metaK    = idxQ - IDX_W'(4);

  always_comb begin
    curByte = ERR_BYTE;
    unique case (kindQ)
      RK_SAMPLE: curByte = (idxQ == '0) ? 8'(sampleQ >> 8) : sampleQ[7:0];
      RK_META: begin
        if (idxQ < IDX_W'(4))       curByte = 8'(32'(META_BODY) >> {idxQ[1:0], 3'b000});
        else if (metaK == '0)       curByte = 8'(NUM_CH);
        else if (metaK == IDX_W'(1)) curByte = 8'(NUM_ACT);
        else                        curByte = 8'(metaK) ^ 8'hA5;
      end
      RK_CHAN: begin
        case (idxQ[2:0])
          3'd0: curByte = 8'h01;
          3'd1: curByte = 8'h00;
          3'd2: curByte = 8'(chanQ - 5'd1);
          3'd3: curByte = 8'(SAMPLE_W);
          3'd4: curByte = 8'h11;
          3'd5: curByte = 8'h01;
          3'd6: curByte = 8'h43;
          default: curByte = 8'h01;
        endcase
      end
      RK_ACK:  curByte = ACK_BYTE;
      RK_TEST: curByte = faultQ;
      default: curByte = ERR_BYTE;
    endcase
  end

  a_r3_sample_high_nibble: assert property (@(posedge clk) disable iff (!rstN)
    (kindQ == RK_SAMPLE && idxQ == '0) |-> curByte[7:4] == 4'h0);
  a_r5_index_in_reply: assert property (@(posedge clk) disable iff (!rstN)
    idxQ < replyLen);
endmodule

// File: rtl/xdcr_control.sv
module xdcr_control
  import xdcr_pkg::*;
#(
  parameter int NUM_CH  = 17,
  parameter int NUM_ACT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  output logic       rxReady,
  output logic       txValid,
  input  logic       txReady,
  output logic       adcReq,
  input  logic       adcValid,
  input  logic [4:0] chanQ,
  input  logic       lastByte,
  output dpCmd_t     cmd
);
  localparam logic [5:0] CH_LIMIT  = 6'(NUM_CH);
  localparam logic [5:0] ACT_LIMIT = 6'(NUM_ACT);

  typedef enum logic [1:0] {ST_IDLE, ST_ADC, ST_ACTDATA, ST_SEND} state_t;
  state_t state, stateNext;

  logic       isRead;
  logic [1:0] fnCode;
  logic [5:0] chanIn;

  assign isRead = rxData[7];
  assign fnCode = rxData[6:5];
  assign chanIn = {1'b0, rxData[4:0]};

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    cmd       = '0;
    stateNext = state;
    rxReady   = (state == ST_IDLE) || (state == ST_ACTDATA);
    txValid   = (state == ST_SEND);
    adcReq    = (state == ST_ADC);
    unique case (state)
      ST_IDLE: if (rxValid) begin
        cmd.latchAddr = 1'b1;
        cmd.setKind   = 1'b1;
        cmd.kind      = RK_ERR;
        stateNext     = ST_SEND;
        unique case (fnCode)
          FN_SENSOR: if (isRead && chanIn < CH_LIMIT) begin
            cmd.setKind = 1'b0;
            stateNext   = ST_ADC;
          end
          FN_SHEET: if (isRead && chanIn <= CH_LIMIT)
            cmd.kind = (chanIn == '0) ? RK_META : RK_CHAN;
          FN_ACT: if (!isRead) begin
            cmd.setKind = 1'b0;
            stateNext   = ST_ACTDATA;
          end
          default: if (isRead) cmd.kind = RK_TEST;
        endcase
      end
      ST_ADC: if (adcValid) begin
        cmd.latchSample = 1'b1;
        cmd.setKind     = 1'b1;
        cmd.kind        = RK_SAMPLE;
        stateNext       = ST_SEND;
      end
      ST_ACTDATA: if (rxValid) begin
        cmd.setKind = 1'b1;
        if ({1'b0, chanQ} < ACT_LIMIT) begin
          cmd.writeAct = 1'b1;
          cmd.kind     = RK_ACK;
        end else begin
          cmd.kind = RK_ERR;
        end
        stateNext = ST_SEND;
      end
      default: if (txReady) begin
        if (lastByte) stateNext   = ST_IDLE;
        else          cmd.advance = 1'b1;
      end
    endcase
  end

  a_r10_no_rx_while_reply: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !rxReady);
  a_r10_tx_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid);
  a_r3_adc_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (adcReq && !adcValid) |=> adcReq);
endmodule

// File: rtl/xdcr_dispatch.sv
module xdcr_dispatch
  import xdcr_pkg::*;
#(
  parameter int NUM_CH    = 17,
  parameter int NUM_ACT   = 4,
  parameter int SAMPLE_W  = 12,
  parameter int META_BODY = 96
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxValid,
  input  logic [7:0]           rxData,
  output logic                 rxReady,
  output logic                 txValid,
  output logic [7:0]           txData,
  input  logic                 txReady,
  output logic                 adcReq,
  output logic [4:0]           adcChan,
  input  logic                 adcValid,
  input  logic [SAMPLE_W-1:0]  adcData,
  input  logic [7:0]           faultIn,
  output logic [8*NUM_ACT-1:0] actOut
);
  dpCmd_t     cmd;
  logic [4:0] chanQ;
  logic       lastByte;

  xdcr_control #(.NUM_CH(NUM_CH), .NUM_ACT(NUM_ACT)) u_control (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txReady(txReady), .adcReq(adcReq), .adcValid(adcValid),
    .chanQ(chanQ), .lastByte(lastByte), .cmd(cmd)
  );

  xdcr_datapath #(.NUM_CH(NUM_CH), .NUM_ACT(NUM_ACT), .SAMPLE_W(SAMPLE_W),
                  .META_BODY(META_BODY)) u_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rxData(rxData), .adcData(adcData),
    .faultIn(faultIn), .chanQ(chanQ), .curByte(txData), .lastByte(lastByte),
    .actOut(actOut)
  );

  assign adcChan = chanQ;

  a_r10_tx_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> $stable(txData));
  a_r3_adc_chan_range: assert property (@(posedge clk) disable iff (!rstN)
    adcReq |-> ({1'b0, adcChan} < 6'(NUM_CH)));
  a_r7_act_only_on_byte: assert property (@(posedge clk) disable iff (!rstN)
    (actOut != $past(actOut)) |-> $past(rxValid && rxReady));
endmodule

// File: tb/xdcr_dispatch_bench.sv
module xdcr_dispatch_bench;
  logic clk = 0;
  logic rstN = 0;
  logic rxValid = 0;
  logic [7:0] rxData = 0;
  logic rxReady, txValid, txReady = 0;
  logic [7:0] txData;
  logic adcReq, adcValid;
  logic [4:0] adcChan;
  logic [11:0] adcData;
  logic [7:0] faultIn = 0;
  logic [31:0] actOut;

  int nChecks = 0, nFail = 0, adcCount = 0;
  logic [4:0] lastChan = 0;
  logic [11:0] nextSample = 0;
  logic [31:0] actModel = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xdcr_dispatch u_xdcr_dispatch (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txReady(txReady), .adcReq(adcReq),
    .adcChan(adcChan), .adcValid(adcValid), .adcData(adcData), .faultIn(faultIn),
    .actOut(actOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // converter model: random latency, sample taken from nextSample
  initial begin
    adcValid = 0; adcData = 0;
    forever begin
      @(negedge clk);
      if (adcReq) begin
        adcCount++;
        lastChan = adcChan;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        adcValid = 1; adcData = nextSample;
        @(negedge clk);
        adcValid = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  // 0 err, 1 sample, 2 meta, 3 channel sheet, 4 ack, 5 self-test
  function automatic int expKind(input logic [7:0] a);
    logic rd = a[7];
    int ch = a[4:0];
    case (a[6:5])
      2'b00: return (rd && ch < 17) ? 1 : 0;
      2'b01: return !rd ? 0 : (ch == 0 ? 2 : (ch <= 17 ? 3 : 0));
      2'b10: return rd ? 0 : (ch < 4 ? 4 : 0);
      default: return rd ? 5 : 0;
    endcase
  endfunction

  function automatic int expLen(input int k);
    return k == 1 ? 2 : k == 2 ? 100 : k == 3 ? 8 : 1;
  endfunction

  function automatic logic [7:0] expByte(input logic [7:0] a, input int i,
                                         input logic [11:0] s, input logic [7:0] f);
    int k = expKind(a);
    int m;
    case (k)
      1: return i == 0 ? {4'h0, s[11:8]} : s[7:0];
      2: begin
        if (i < 4) return i == 0 ? 8'h60 : 8'h00;
        m = i - 4;
        if (m == 0) return 8'd17;
        if (m == 1) return 8'd4;
        return 8'(m) ^ 8'hA5;
      end
      3: case (i)
        0: return 8'h01;  1: return 8'h00;
        2: return 8'(a[4:0] - 5'd1);  3: return 8'd12;
        4: return 8'h11;  5: return 8'h01;
        6: return 8'h43;  default: return 8'h01;
      endcase
      4: return 8'hAC;
      5: return f;
      default: return 8'hEE;
    endcase
  endfunction

  function automatic string reqTag(input logic [7:0] a);
    logic rd = a[7];
    case (a[6:5])
      2'b00: return !rd ? "R9" : (a[4:0] < 17 ? "R3" : "R4");
      2'b01: return !rd ? "R9" : (a[4:0] == 0 ? "R5" : "R6");
      2'b10: return rd ? "R9" : "R7";
      default: return rd ? "R8" : "R9";
    endcase
  endfunction

  task automatic sendByte(input logic [7:0] b);
    rxValid = 1; rxData = b;
    while (!rxReady) @(negedge clk);
    @(negedge clk);
    rxValid = 0;
  endtask

  task automatic getByte(output logic [7:0] b);
    bit got = 0;
    while (!got) begin
      txReady = ($urandom_range(0, 3) != 0);
      if (txValid && txReady) begin
        b = txData; got = 1;
        @(negedge clk);
      end else begin
        bit held = txValid;
        logic [7:0] prev = txData;
        @(negedge clk);
        if (held) check(txValid && txData == prev, "R10 held reply byte", txData, prev);
      end
    end
    txReady = 0;
  endtask

  task automatic doRequest(input logic [7:0] a, input logic [7:0] d,
                           input logic [11:0] s, input logic [7:0] f);
    int k = expKind(a);
    string tag = reqTag(a);
    int adc0 = adcCount;
    int adcExp = (a[7] && a[6:5] == 2'b00 && a[4:0] < 17) ? 1 : 0;
    logic [7:0] b;
    faultIn = f; nextSample = s;
    sendByte(a);
    if (!a[7] && a[6:5] == 2'b10) begin
      check(!txValid && actOut == actModel, "R7 no reply or write before data byte", actOut, actModel);
      sendByte(d);
      if (a[4:0] < 4) actModel[8*a[4:0] +: 8] = d;
    end
    for (int i = 0; i < expLen(k); i++) begin
      getByte(b);
      check(b == expByte(a, i, s, f), tag, b, expByte(a, i, s, f));
    end
    check(!txValid && rxReady, "R2 back to waiting after reply", {txValid, rxReady}, 2'b01);
    check(actOut == actModel, "R7 actuator outputs", actOut, actModel);
    check(adcCount - adc0 == adcExp, {tag, " converter requests"}, adcCount - adc0, adcExp);
    if (adcExp == 1) check(lastChan == a[4:0], "R3 adcChan", lastChan, a[4:0]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(rxReady && !txValid && !adcReq, "R1 reset handshake", {rxReady, txValid, adcReq}, 3'b100);
    check(actOut == 0, "R1 reset actuators", actOut, 0);

    doRequest(8'h80, 8'h00, 12'hFFF, 8'h00);   // R3 ch0 all ones
    doRequest(8'h90, 8'h00, 12'h000, 8'h00);   // R3 ch16 zeros
    doRequest(8'h91, 8'h00, 12'h5A5, 8'h00);   // R4 ch17
    doRequest(8'hA0, 8'h00, 12'h000, 8'h00);   // R5 module sheet
    doRequest(8'hA1, 8'h00, 12'h000, 8'h00);   // R6 ch1
    doRequest(8'hB1, 8'h00, 12'h000, 8'h00);   // R6 ch17
    doRequest(8'hB2, 8'h00, 12'h000, 8'h00);   // R6 ch18 error
    doRequest(8'h43, 8'h5A, 12'h000, 8'h00);   // R7 ch3
    doRequest(8'h44, 8'h77, 12'h000, 8'h00);   // R7 ch4 error
    doRequest(8'hE0, 8'h00, 12'h000, 8'h00);   // R8 pass
    doRequest(8'hE0, 8'h00, 12'h000, 8'h81);   // R8 faults
    doRequest(8'h05, 8'h00, 12'h123, 8'h00);   // R9 write to sensor
    doRequest(8'hC1, 8'h00, 12'h000, 8'h00);   // R9 read of actuator
    doRequest(8'hE0, 8'h00, 12'h000, 8'h3C);   // R9 next byte is a new request
    doRequest(8'h60, 8'h00, 12'h000, 8'h00);   // R9 write to self-test
    doRequest(8'h20, 8'h00, 12'h000, 8'h00);   // R9 write to data sheet

    for (int n = 0; n < 400; n++)
      doRequest(8'($urandom), 8'($urandom), 12'($urandom), 8'($urandom));

    finishRun();
  end
endmodule